// File: doc/BRIEF.md
# Prescaled Reloadable Interval Timer

A single-channel 32-bit down-counting timer. A two-bit selector in the control word picks one of up to four tick inputs. The tick inputs are enable strobes in the main clock domain, so the block uses no clock other than its own. A power-of-two prescaler, set by a three-bit code, follows the selector. Each output pulse of the prescaler moves the counter down by one.

Software programs the block through a flat write/read port. One address holds the control word, one holds the interval, and the current count can be read at a third. A one-bit interrupt enable and a one-bit pending flag each have an address of their own. When the count reaches the end of an interval, the pending flag is set. In periodic mode the count then restarts from the interval. In single-shot mode the count stays at zero and the block clears its own enable.

Top module: `ivt_timer`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is low. The register addresses are: 0 control, 1 interval, 2 current count, 3 interrupt enable, 4 pending status. Unused addresses read 0.
- R2: The control word has these fields: bit 0 is the run enable, bits 3:2 are the source select, bits 6:4 are the prescale code and bit 7 is the mode (0 periodic, 1 single-shot). A read returns these fields as written. Bit 1 and bits 31:8 always read 0.
- R3: A control write with bit 1 set copies the interval register into the current count on the next clock edge, whether or not the timer runs. It also restarts the prescaler phase. Bit 1 does not stay set.
- R4: Only strobes on the tick input chosen by the source select advance the prescaler. Strobes on the other inputs have no effect on the count.
- R5: With prescale code p (0 to 7), the count falls by exactly one for every 2^p strobes on the selected input.
- R6: In periodic mode, a decrement step taken at count 1 loads the interval into the count, and the run enable stays set.
- R7: In single-shot mode, a decrement step taken at count 1 leaves the count at 0 and clears the run enable. Later strobes leave the count at 0.
- R8: A step from count 1 sets the pending flag (status bit 0) even when the interrupt enable is 0.
- R9: Writing 1 to status bit 0 clears the pending flag. Writing 0 has no effect. If an expiry happens in the same cycle as the clearing write, the flag stays set.
- R10: `irq` is high exactly when the pending flag and the interrupt enable (bit 0 at address 3) are both 1.
- R11: While the run enable is 0, the count does not change, except through a reload request.
- R12: A step taken while the count is 0 causes no expiry and leaves the pending flag unchanged. In periodic mode the step loads the interval into the count. In single-shot mode the count stays at 0 and the run enable clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register address for both read and write |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| tick_src | input | NUM_SRC | Tick strobes, one per selectable source |
| irq | output | 1 | Interrupt request: pending AND enable |

## Verification
Directed sequences check each behaviour in turn:
- Strobes on unselected inputs only, then a single strobe on the selected input. This separates a correct source selector from a wrong index.
- A prescale of 8, with the count sampled one strobe before the divide boundary and again at it. This catches off-by-one phase errors.
- An expiry in periodic mode and an expiry in single-shot mode. This separates reload-on-expiry from stop-on-expiry.
- A clearing write that lands in the same cycle as an expiry. This checks the set-over-clear priority.

After the directed sequences, seeded random traffic mixes short intervals, small prescale codes, mode changes and random strobe patterns. On every cycle the read data and `irq` are compared with a reference model in the bench. This reaches reloads and control writes in the middle of a count, which the directed cases do not.

// File: rtl/ivt_pkg.sv
// Package: shared field positions, register addresses and control layout
// for the interval timer. Assumes at most four tick sources (2-bit select)
// and a 3-bit prescale code.
package ivt_pkg;
    localparam int ADDR_W   = 3;
    localparam int SRC_W    = 2;
    localparam int PRE_W    = 3;

    localparam int BIT_RUN  = 0;
    localparam int BIT_RLD  = 1;
    localparam int SRC_LSB  = 2;
    localparam int PRE_LSB  = 4;
    localparam int BIT_MODE = 7;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_INTV = 3'd1;
    localparam logic [ADDR_W-1:0] A_CURR = 3'd2;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

    typedef struct packed {
        logic             single;
        logic [PRE_W-1:0] pre;
        logic [SRC_W-1:0] src;
        logic             run;
    } ctrl_t;
endpackage

// File: rtl/ivt_prescaler.sv
// Module: source selector plus power-of-two prescaler.
// Picks one tick strobe and emits one step per 2^pre selected strobes.
// Assumes the strobes are single-cycle enables in the clk domain. The phase
// restarts whenever the timer is stopped or a reload is requested.
module ivt_prescaler
    import ivt_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               clear,
    input  logic [SRC_W-1:0]   src_sel,
    input  logic [PRE_W-1:0]   pre_sel,
    input  logic [NUM_SRC-1:0] ticks,
    output logic               step
);
    localparam int PCW = (1 << PRE_W) - 1;

    logic [NUM_SRC-1:0] hit;
    logic               sel_tick;
    logic [PCW-1:0]     limit;
    logic [PCW-1:0]     pcnt;
    logic               at_limit;

    // Mask each source by its select match
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = ticks[g] & (src_sel == SRC_W'(g));
    end

    assign sel_tick = |hit;
    // PCW - pre equals ~pre because PCW is all ones in PRE_W bits
    assign limit    = {PCW{1'b1}} >> (~pre_sel);
    assign at_limit = (pcnt >= limit);
    assign step     = run & ~clear & sel_tick & at_limit;

    // Phase counter: counts selected strobes up to the divide limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clear || !run) begin
            pcnt <= '0;
        end else if (sel_tick) begin
            pcnt <= at_limit ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/ivt_core.sv
// Module: the down counter proper. Loads on request, decrements on step,
// and on expiry either restarts from the interval or parks at zero.
// Assumes load and step may coincide (load wins).
module ivt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             single,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             stop
);
    logic above_one;
    logic is_one;

    assign above_one = (cnt > CNT_W'(1));
    assign is_one    = (cnt == CNT_W'(1));
    assign expire    = step & ~load & is_one;
    assign stop      = step & ~load & single & ~above_one;

    // Count register: reload, decrement, or end-of-interval handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step) begin
            if (above_one)   cnt <= cnt - 1'b1;
            else if (single) cnt <= '0;
            else             cnt <= load_val;
        end
    end
endmodule

// File: rtl/ivt_timer.sv
// Module: top of the interval timer. Decodes the register port, holds
// control/interval/interrupt state and joins prescaler and counter.
// Assumes a single-cycle write strobe; rdata is combinational from addr.
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   rdata,
    input  logic [NUM_SRC-1:0] tick_src,
    output logic               irq
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] intv_q;
    logic [CNT_W-1:0] cur_cnt;
    logic             ien_q;
    logic             pend_q;
    logic             ctrl_wr;
    logic             reload_req;
    logic             tick_step;
    logic             expire;
    logic             stop;
    logic             ctrl_en;
    logic             ctrl_mode;

    assign ctrl_wr    = wr_en && (addr == A_CTRL);
    assign reload_req = ctrl_wr && wdata[BIT_RLD];
    assign ctrl_en    = ctrl_q.run;
    assign ctrl_mode  = ctrl_q.single;

    ivt_prescaler #(.NUM_SRC(NUM_SRC)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.run),
        .clear   (reload_req),
        .src_sel (ctrl_q.src),
        .pre_sel (ctrl_q.pre),
        .ticks   (tick_src),
        .step    (tick_step)
    );

    ivt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload_req),
        .load_val (intv_q),
        .step     (tick_step),
        .single   (ctrl_q.single),
        .cnt      (cur_cnt),
        .expire   (expire),
        .stop     (stop)
    );

    // Control word: software write wins over single-shot self-stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.run    <= wdata[BIT_RUN];
            ctrl_q.src    <= wdata[SRC_LSB +: SRC_W];
            ctrl_q.pre    <= wdata[PRE_LSB +: PRE_W];
            ctrl_q.single <= wdata[BIT_MODE];
        end else if (stop) begin
            ctrl_q.run <= 1'b0;
        end
    end

    // Interval and interrupt-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intv_q <= '0;
            ien_q  <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_INTV) intv_q <= wdata;
            if (addr == A_IEN)  ien_q  <= wdata[0];
        end
    end

    // Pending flag: set on expiry, write-one-to-clear, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (expire) begin
            pend_q <= 1'b1;
        end else if (wr_en && (addr == A_STAT) && wdata[0]) begin
            pend_q <= 1'b0;
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[BIT_RUN]               = ctrl_q.run;
                rdata[SRC_LSB +: SRC_W]      = ctrl_q.src;
                rdata[PRE_LSB +: PRE_W]      = ctrl_q.pre;
                rdata[BIT_MODE]              = ctrl_q.single;
            end
            A_INTV:  rdata    = intv_q;
            A_CURR:  rdata    = cur_cnt;
            A_IEN:   rdata[0] = ien_q;
            A_STAT:  rdata[0] = pend_q;
            default: rdata    = '0;
        endcase
    end

    assign irq = pend_q & ien_q;
endmodule

// File: rtl/ivt_timer_chk.sv
// Module: property checker for ivt_timer, attached by bind below.
// Assumes the bound signals are the counter, interval, control and flag state.
module ivt_timer_chk
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wbit0,
    input logic              wbit1,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  intv,
    input logic              en,
    input logic              mode,
    input logic              step,
    input logic              pend,
    input logic              ien
);
    logic rld;
    logic cwr;
    logic clr;
    assign cwr = wr_en && (addr == A_CTRL);
    assign rld = cwr && wbit1;
    assign clr = wr_en && (addr == A_STAT) && wbit0;

    AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        rld |=> (cnt == $past(intv))); // R3
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !rld) |=> (cnt == $past(cnt))); // R11
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rld && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1)); // R5
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && !rld && cnt == CNT_W'(1)) |=> pend); // R8
    AST_ONESHOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode && step && !cwr && cnt <= CNT_W'(1)) |=> (!en && cnt == '0)); // R7
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mode && step && !rld && cnt <= CNT_W'(1)) |=> (cnt == $past(intv))); // R6
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien || !pend) |-> !irq); // R10
    AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(en && step && !rld && cnt == CNT_W'(1))) |=> !pend); // R9
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wbit0 (wdata[0]),
    .wbit1 (wdata[1]),
    .irq   (irq),
    .cnt   (cur_cnt),
    .intv  (intv_q),
    .en    (ctrl_en),
    .mode  (ctrl_mode),
    .step  (tick_step),
    .pend  (pend_q),
    .ien   (ien_q)
);

// File: tb/ivt_timer_tb.sv
// Bench: directed corner cases followed by seeded random traffic, each cycle
// compared against a reference model kept in bench variables.
module ivt_timer_tb;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic [3:0]    tick_src = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int unsigned seed_val;

    // Reference state
    logic          m_run, m_single;
    logic [1:0]    m_src;
    logic [2:0]    m_pre;
    logic [CW-1:0] m_intv, m_cnt;
    int            m_pcnt;
    logic          m_ien, m_pend;

    always #5 clk = ~clk;

    ivt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_src(tick_src), .irq(irq)
    );

    task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] exp_read(input logic [2:0] a);
        logic [CW-1:0] r;
        r = '0;
        case (a)
            3'd0: r = {24'd0, m_single, m_pre, m_src, 1'b0, m_run};
            3'd1: r = m_intv;
            3'd2: r = m_cnt;
            3'd3: r[0] = m_ien;
            3'd4: r[0] = m_pend;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd2: return "R5";
            3'd3: return "R10";
            3'd4: return "R8";
            default: return "R1";
        endcase
    endfunction

    // Advance the model by one clock edge with the given inputs
    task automatic model_edge(input logic w, input logic [2:0] a,
                              input logic [CW-1:0] d, input logic [3:0] t);
        logic rl, sel, stp, exp_hit, stp_off;
        int   lim;
        rl  = w && a == 3'd0 && d[1];
        lim = (1 << m_pre) - 1;
        sel = t[m_src];
        stp = m_run && !rl && sel && (m_pcnt >= lim);
        exp_hit = stp && m_cnt == 1;
        stp_off = stp && m_single && m_cnt <= 1;
        if (rl || !m_run) m_pcnt = 0;
        else if (sel) m_pcnt = (m_pcnt >= lim) ? 0 : m_pcnt + 1;
        if (rl) m_cnt = m_intv;
        else if (stp) m_cnt = (m_cnt > 1) ? m_cnt - 1 : (m_single ? '0 : m_intv);
        if (exp_hit) m_pend = 1'b1;
        else if (w && a == 3'd4 && d[0]) m_pend = 1'b0;
        if (w && a == 3'd0) begin
            m_run = d[0]; m_src = d[3:2]; m_pre = d[6:4]; m_single = d[7];
        end else if (stp_off) m_run = 1'b0;
        if (w && a == 3'd1) m_intv = d;
        if (w && a == 3'd3) m_ien = d[0];
    endtask

    // One cycle: drive at negedge, update model, sample after posedge
    task automatic cyc(input logic w, input logic [2:0] a,
                       input logic [CW-1:0] d, input logic [3:0] t);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; tick_src = t;
        model_edge(w, a, d, t);
        @(posedge clk);
        #1;
        chk(read_tag(a), rdata, exp_read(a));
        chk("R10", {31'd0, irq}, {31'd0, m_ien & m_pend});
    endtask

    task automatic rd(input logic [2:0] a, input logic [CW-1:0] exp, input string tag);
        cyc(1'b0, a, '0, 4'd0);
        chk(tag, rdata, exp);
    endtask

    task automatic ticks(input int n, input logic [3:0] t);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd2, '0, t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_run = 0; m_single = 0; m_src = 0; m_pre = 0; m_intv = 0;
        m_cnt = 0; m_pcnt = 0; m_ien = 0; m_pend = 0;
        seed_val = 32'd12345;
        void'($urandom(seed_val));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 6; a++) rd(3'(a), '0, "R1");
        chk("R1", {31'd0, irq}, '0);

        // R3 reload while stopped, bit 1 not kept
        cyc(1'b1, 3'd1, 32'd5, 4'd0);
        cyc(1'b1, 3'd0, 32'h2, 4'd0);
        rd(3'd2, 32'd5, "R3");
        rd(3'd0, 32'd0, "R3");

        // R11 stopped counter ignores strobes
        ticks(6, 4'hF);
        rd(3'd2, 32'd5, "R11");

        // R2 readback and R4 source select (source 2, divide 1)
        cyc(1'b1, 3'd0, 32'h9, 4'd0);
        rd(3'd0, 32'h9, "R2");
        ticks(8, 4'b1011);
        rd(3'd2, 32'd5, "R4");
        ticks(1, 4'b0100);
        rd(3'd2, 32'd4, "R4");

        // R5 divide by 8 from source 0, with reload
        cyc(1'b1, 3'd0, 32'h33, 4'd0);
        rd(3'd0, 32'h31, "R3");
        rd(3'd2, 32'd5, "R3");
        ticks(7, 4'b0001);
        rd(3'd2, 32'd5, "R5");
        ticks(1, 4'b0001);
        rd(3'd2, 32'd4, "R5");

        // R6 periodic expiry and R8 pending with interrupt disabled
        cyc(1'b1, 3'd1, 32'd3, 4'd0);
        cyc(1'b1, 3'd0, 32'h3, 4'd0);
        ticks(2, 4'b0001);
        rd(3'd2, 32'd1, "R6");
        rd(3'd4, 32'd0, "R8");
        ticks(1, 4'b0001);
        rd(3'd2, 32'd3, "R6");
        rd(3'd0, 32'h1, "R6");
        rd(3'd4, 32'd1, "R8");
        chk("R10", {31'd0, irq}, '0);

        // R9 write-one-to-clear and R10 masking
        cyc(1'b1, 3'd4, 32'd0, 4'd0);
        rd(3'd4, 32'd1, "R9");
        cyc(1'b1, 3'd3, 32'd1, 4'd0);
        chk("R10", {31'd0, irq}, 32'd1);
        cyc(1'b1, 3'd4, 32'd1, 4'd0);
        rd(3'd4, 32'd0, "R9");
        chk("R10", {31'd0, irq}, '0);

        // R9 expiry beats a clearing write in the same cycle
        ticks(2, 4'b0001);
        cyc(1'b1, 3'd4, 32'd1, 4'b0001);
        rd(3'd4, 32'd1, "R9");
        cyc(1'b1, 3'd4, 32'd1, 4'd0);

        // R7 single-shot stop
        cyc(1'b1, 3'd1, 32'd2, 4'd0);
        cyc(1'b1, 3'd0, 32'h83, 4'd0);
        ticks(2, 4'b0001);
        rd(3'd2, 32'd0, "R7");
        rd(3'd0, 32'h80, "R7");
        rd(3'd4, 32'd1, "R7");
        ticks(3, 4'b0001);
        rd(3'd2, 32'd0, "R7");
        cyc(1'b1, 3'd4, 32'd1, 4'd0);

        // R2 upper bits and bit 1 read zero
        cyc(1'b1, 3'd0, 32'hFFFF_FF7C, 4'd0);
        rd(3'd0, 32'h7C, "R2");

        // R12 periodic step from zero loads interval, no expiry
        cyc(1'b1, 3'd0, 32'h1, 4'd0);
        ticks(1, 4'b0001);
        rd(3'd2, 32'd2, "R12");
        rd(3'd4, 32'd0, "R12");
        cyc(1'b1, 3'd0, 32'h0, 4'd0);

        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic          w;
            logic [2:0]    a;
            logic [CW-1:0] d;
            w = ($urandom % 8) == 0;
            a = 3'($urandom % 6);
            d = $urandom;
            if (a == 3'd1) d = $urandom % 7;
            if (a == 3'd0) d[6:4] = 3'($urandom % 3);
            cyc(w, a, d, 4'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule